// File: doc/BRIEF.md
# Prioritized Event Acceptance Controller

This block sits beside the fetch stage of a small processor core and decides, once per cycle, whether one of the pending events is taken. The events are a debug request, four critical faults, a parameterised number of exceptions, and four interrupt levels. Each source is gated by mask bits in the current status word, except the critical faults, which are always eligible. The highest-priority eligible source wins.

When an event is taken, the block produces a redirect in a single step. The redirect raises a one-cycle accept strobe. It gives a new status word, in which the mode field is rewritten and the mask bits of the winning level and every level below it are set. It gives a new program counter, read from the winner's slot in a handler-address table, and the register bank that matches the new mode.

Debug entry keeps the interrupted PC and status in a private pair of registers, not on a stack. A debug-return command restores that pair through the same redirect outputs. The core is expected to load `srNew`/`pcNew` whenever a strobe is high. Request lines are levels held by their sources, so a masked request simply waits.

Top module: `evt_accept_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it, `acceptOut`, `returnOut`, `srNew`, `pcNew` and `bankSel` are all zero.
- R2: Priority runs from highest to lowest as follows. Debug comes first. Then `critReq[0]` to `critReq[3]`. Then `excReq[0]` upward. Then `intReq[3]` down to `intReq[0]`. Table slot k (bits k*AW +: AW of `handlerTable`) belongs to the k-th source in this order, so the slots are debug 0, critical 1–4, exceptions 5.., and interrupts after them.
- R3: Status bits are: bit0 global interrupt mask, bits1–4 masks for levels 0–3, bit5 exception mask, bit6 debug mask, bit7 debug-active flag, bits10:8 mode. An interrupt of level n is eligible only when bit0 and bit(1+n) are both clear. An exception is eligible only when bit5 is clear. A debug request is eligible only when bit6 is clear.
- R4: A critical request is eligible whatever the mask bits hold.
- R5: On acceptance, `pcNew` equals the winner's table slot.
- R6: The new mode is 2+n for interrupt level n, 6 for an exception or debug, and 7 for a critical fault. `bankSel` is n+1 for interrupt level n, 5 for modes 6 and 7, and 0 for modes 0 and 1.
- R7: On acceptance, mask bits that are already set stay set. Interrupt level n additionally sets bits 1..1+n. An exception or critical fault sets bits 0–5. Debug sets bits 0–7. Status bits 11 and above pass through unchanged.
- R8: Debug acceptance sets the debug-active flag and stores the current `pcCur`/`srCur` in the private debug pair.
- R9: `dbgRet` is honoured only while `srCur` bit7 is set. It then raises `returnOut` instead of `acceptOut` and restores the saved pair on `srNew`/`pcNew`, and it takes precedence over every event in the same cycle. While bit7 is clear, `dbgRet` has no effect.
- R10: The strobe and the new status, PC and bank appear together one cycle after the deciding cycle. The cycle after any strobe is never itself a deciding cycle, so strobes are never adjacent.
- R11: A request that is masked leaves the outputs unchanged. It is accepted in the first free cycle after its mask clears, provided it is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgReq | input | 1 | Debug request level |
| critReq | input | 4 | Critical fault request levels |
| excReq | input | NUM_EXC | Exception request levels |
| intReq | input | 4 | Interrupt request levels, bit n = level n |
| dbgRet | input | 1 | Return-from-debug command |
| srCur | input | 16 | Current status word |
| pcCur | input | AW | Current program counter |
| handlerTable | input | (9+NUM_EXC)*AW | Handler addresses, one slot per source |
| acceptOut | output | 1 | One-cycle event acceptance strobe |
| returnOut | output | 1 | One-cycle debug-return strobe |
| srNew | output | 16 | Status word to load |
| pcNew | output | AW | Program counter to load |
| bankSel | output | 3 | Register bank for the new mode |

## Verification
Each result is due exactly one clock after the cycle whose inputs decide it. The strobe, the new status word, the new PC and the bank all come from the same register stage, so they are checked together in one comparison, half a period after the edge that loads them. The bench's behavioural model takes its decision at each rising edge from the inputs held since the previous falling edge. It also skips the cycle right after any strobe, so the one-cycle blackout is part of every comparison. Directed sequences insert an empty cycle wherever a fresh decision is wanted, and then sample the result on the next falling edge.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int SR_W    = 16;
  localparam int GM_B    = 0;
  localparam int I0M_B   = 1;
  localparam int EM_B    = 5;
  localparam int DM_B    = 6;
  localparam int D_B     = 7;
  localparam int MODE_LO = 8;
  localparam int MODE_W  = 3;
  localparam int MASK_W  = D_B + 1;
  localparam int NUM_CRIT = 4;
  localparam int NUM_LVL  = 4;
  localparam int IDX_W    = 8;

  localparam logic [MODE_W-1:0] MODE_INT0 = 3'd2;
  localparam logic [MODE_W-1:0] MODE_EXC  = 3'd6;
  localparam logic [MODE_W-1:0] MODE_CRIT = 3'd7;

  typedef enum logic [1:0] {CLS_DBG, CLS_CRIT, CLS_EXC, CLS_INT} evtClass_e;

  typedef struct packed {
    logic             take;
    logic             restore;
    logic             saveDbg;
    evtClass_e        cls;
    logic [1:0]       intLvl;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;
endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_EXC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dbgReq,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic [NUM_EXC-1:0] excReq,
  input  logic [NUM_LVL-1:0] intReq,
  input  logic               dbgRet,
  input  logic [MASK_W-1:0]  srMask,
  output ctrlStrobe_t        strb
);
  localparam int EXC_BASE = 1 + NUM_CRIT;
  localparam int INT_BASE = EXC_BASE + NUM_EXC;
  localparam int N_SRC    = INT_BASE + NUM_LVL;

  logic [N_SRC-1:0] elig;
  logic [IDX_W-1:0] winIdx;
  logic             anyElig;
  logic             busyQ;
  logic             restoreNow;
  logic             takeNow;

  // eligibility per source, in priority order
  always_comb begin
    elig = '0;
    elig[0] = dbgReq & ~srMask[DM_B];
    elig[EXC_BASE-1:1] = critReq;
    elig[EXC_BASE +: NUM_EXC] = excReq & {NUM_EXC{~srMask[EM_B]}};
    for (int l = 0; l < NUM_LVL; l++) begin
      elig[INT_BASE+l] = intReq[NUM_LVL-1-l] & ~srMask[GM_B] & ~srMask[I0M_B+NUM_LVL-1-l];
    end
  end

  // lowest index wins
  always_comb begin
    winIdx  = '0;
    anyElig = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        winIdx  = IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  assign restoreNow = dbgRet & srMask[D_B] & ~busyQ;
  assign takeNow    = anyElig & ~busyQ & ~restoreNow;

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= takeNow | restoreNow;
  end

  always_comb begin
    strb.take    = takeNow;
    strb.restore = restoreNow;
    strb.idx     = winIdx;
    strb.intLvl  = 2'(NUM_LVL - 1 - (int'(winIdx) - INT_BASE));
    if (winIdx == '0)                         strb.cls = CLS_DBG;
    else if (winIdx < IDX_W'(EXC_BASE))       strb.cls = CLS_CRIT;
    else if (winIdx < IDX_W'(INT_BASE))       strb.cls = CLS_EXC;
    else                                      strb.cls = CLS_INT;
    strb.saveDbg = takeNow & (winIdx == '0);
  end
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
#(
  parameter int NUM_EXC = 4,
  parameter int AW      = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrlStrobe_t                        strb,
  input  logic [SR_W-1:0]                    srCur,
  input  logic [AW-1:0]                      pcCur,
  input  logic [(1+NUM_CRIT+NUM_EXC+NUM_LVL)*AW-1:0] handlerTable,
  output logic                               acceptOut,
  output logic                               returnOut,
  output logic [SR_W-1:0]                    srNew,
  output logic [AW-1:0]                      pcNew,
  output logic [2:0]                         bankSel
);
  logic [SR_W-1:0]   setMask;
  logic [MODE_W-1:0] modeNext;
  logic [SR_W-1:0]   srNext;
  logic [AW-1:0]     pcNext;
  logic [SR_W-1:0]   dbgSrQ;
  logic [AW-1:0]     dbgPcQ;

  function automatic logic [2:0] bankOf(input logic [MODE_W-1:0] m);
    if (m >= MODE_EXC)       return 3'd5;
    else if (m >= MODE_INT0) return 3'(m - 3'd1);
    else                     return 3'd0;
  endfunction

  always_comb begin
    setMask  = '0;
    modeNext = MODE_EXC;
    unique case (strb.cls)
      CLS_INT: begin
        for (int l = 0; l < NUM_LVL; l++)
          if (l <= int'(strb.intLvl)) setMask[I0M_B+l] = 1'b1;
        modeNext = MODE_INT0 + {1'b0, strb.intLvl};
      end
      CLS_EXC: begin
        setMask[EM_B:GM_B] = '1;
        modeNext = MODE_EXC;
      end
      CLS_CRIT: begin
        setMask[EM_B:GM_B] = '1;
        modeNext = MODE_CRIT;
      end
      default: begin
        setMask[D_B:GM_B] = '1;
        modeNext = MODE_EXC;
      end
    endcase
    srNext = srCur | setMask;
    srNext[MODE_LO +: MODE_W] = modeNext;
    pcNext = handlerTable[int'(strb.idx)*AW +: AW];
    if (strb.restore) begin
      srNext = dbgSrQ;
      pcNext = dbgPcQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgSrQ <= '0;
      dbgPcQ <= '0;
    end else if (strb.saveDbg) begin
      dbgSrQ <= srCur;
      dbgPcQ <= pcCur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptOut <= 1'b0;
      returnOut <= 1'b0;
      srNew     <= '0;
      pcNew     <= '0;
      bankSel   <= '0;
    end else begin
      acceptOut <= strb.take;
      returnOut <= strb.restore;
      if (strb.take || strb.restore) begin
        srNew   <= srNext;
        pcNew   <= pcNext;
        bankSel <= bankOf(srNext[MODE_LO +: MODE_W]);
      end
    end
  end
endmodule

// File: rtl/evt_accept_top.sv
module evt_accept_top
  import evt_pkg::*;
#(
  parameter int NUM_EXC = 4,
  parameter int AW      = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dbgReq,
  input  logic [3:0]                   critReq,
  input  logic [NUM_EXC-1:0]           excReq,
  input  logic [3:0]                   intReq,
  input  logic                         dbgRet,
  input  logic [15:0]                  srCur,
  input  logic [AW-1:0]                pcCur,
  input  logic [(9+NUM_EXC)*AW-1:0]    handlerTable,
  output logic                         acceptOut,
  output logic                         returnOut,
  output logic [15:0]                  srNew,
  output logic [AW-1:0]                pcNew,
  output logic [2:0]                   bankSel
);
  ctrlStrobe_t strb;

  evt_ctrl #(.NUM_EXC(NUM_EXC)) u_ctrl (
    .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .critReq(critReq),
    .excReq(excReq), .intReq(intReq), .dbgRet(dbgRet),
    .srMask(srCur[MASK_W-1:0]), .strb(strb)
  );

  evt_datapath #(.NUM_EXC(NUM_EXC), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srCur(srCur), .pcCur(pcCur),
    .handlerTable(handlerTable), .acceptOut(acceptOut), .returnOut(returnOut),
    .srNew(srNew), .pcNew(pcNew), .bankSel(bankSel)
  );
endmodule

// File: rtl/evt_accept_chk.sv
module evt_accept_chk
  import evt_pkg::*;
#(
  parameter int NUM_EXC = 4,
  parameter int AW      = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               dbgReq,
  input logic [3:0]         critReq,
  input logic [NUM_EXC-1:0] excReq,
  input logic [3:0]         intReq,
  input logic               dbgRet,
  input logic [MASK_W-1:0]  srMask,
  input logic [AW-1:0]      dbgHandler,
  input logic               acceptOut,
  input logic               returnOut,
  input logic [15:0]        srNew,
  input logic [AW-1:0]      pcNew
);
  logic busy;
  assign busy = acceptOut | returnOut;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptOut && returnOut)); // R9
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy); // R10
  AST_CRIT_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (critReq != 4'd0) && !(dbgRet && srMask[D_B])) |=> (acceptOut && !returnOut)); // R4
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && srMask[GM_B] && !dbgReq && critReq == 4'd0 &&
     (srMask[EM_B] || excReq == '0)) |=> !acceptOut); // R3
  AST_LOWEST_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    acceptOut |-> srNew[I0M_B]); // R7
  AST_DBG_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && dbgReq && !srMask[DM_B] && !(dbgRet && srMask[D_B]))
      |=> (acceptOut && srNew[D_B] && pcNew == $past(dbgHandler))); // R8
  AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && dbgRet && !srMask[D_B] && !dbgReq && critReq == 4'd0 &&
     excReq == '0 && intReq == 4'd0) |=> (!returnOut && !acceptOut)); // R9
endmodule

bind evt_accept_top evt_accept_chk #(.NUM_EXC(NUM_EXC), .AW(AW)) i_chk (
  .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .critReq(critReq), .excReq(excReq),
  .intReq(intReq), .dbgRet(dbgRet), .srMask(srCur[7:0]),
  .dbgHandler(handlerTable[AW-1:0]), .acceptOut(acceptOut), .returnOut(returnOut),
  .srNew(srNew), .pcNew(pcNew)
);

// File: tb/test_evt_accept_top.sv
module test_evt_accept_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EXC = 4;
  localparam int AW = 32;
  localparam int NSRC = 9 + NUM_EXC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgReq = 1'b0;
  logic [3:0] critReq = '0;
  logic [NUM_EXC-1:0] excReq = '0;
  logic [3:0] intReq = '0;
  logic dbgRet = 1'b0;
  logic [15:0] srCur = '0;
  logic [AW-1:0] pcCur = '0;
  logic [NSRC*AW-1:0] handlerTable;
  logic acceptOut, returnOut;
  logic [15:0] srNew;
  logic [AW-1:0] pcNew;
  logic [2:0] bankSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit feedback = 1'b0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_accept_top #(.NUM_EXC(NUM_EXC), .AW(AW)) i_evt_accept_top (
    .clk(clk), .rstN(rstN), .dbgReq(dbgReq), .critReq(critReq), .excReq(excReq),
    .intReq(intReq), .dbgRet(dbgRet), .srCur(srCur), .pcCur(pcCur),
    .handlerTable(handlerTable), .acceptOut(acceptOut), .returnOut(returnOut),
    .srNew(srNew), .pcNew(pcNew), .bankSel(bankSel)
  );

  function automatic logic [AW-1:0] slotAddr(int k);
    return AW'(32'h1000 + k * 32'h40);
  endfunction

  initial begin
    for (int k = 0; k < NSRC; k++) handlerTable[k*AW +: AW] = slotAddr(k);
  end

  function automatic logic [2:0] bankFor(logic [15:0] s);
    int m;
    m = int'(s[10:8]);
    if (m >= 6) return 3'd5;
    if (m >= 2) return 3'(m - 1);
    return 3'd0;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic expAcc = 1'b0, expRet = 1'b0;
  logic [15:0] expSr = '0;
  logic [AW-1:0] expPc = '0;
  logic [2:0] expBank = '0;
  logic [15:0] mSr = '0;
  logic [AW-1:0] mPc = '0;

  always @(posedge clk) begin
    int win;
    int lvl;
    logic [15:0] s;
    if (!rstN) begin
      expAcc <= 1'b0; expRet <= 1'b0; expSr <= '0; expPc <= '0; expBank <= '0;
      mSr <= '0; mPc <= '0;
    end else begin
      win = -1;
      expAcc <= 1'b0;
      expRet <= 1'b0;
      if (!(expAcc || expRet)) begin
        if (dbgRet && srCur[7]) begin
          expRet <= 1'b1; expSr <= mSr; expPc <= mPc; expBank <= bankFor(mSr);
        end else begin
          if (dbgReq && !srCur[6]) win = 0;
          for (int k = 0; k < 4; k++) if (win < 0 && critReq[k]) win = 1 + k;
          for (int k = 0; k < NUM_EXC; k++) if (win < 0 && excReq[k] && !srCur[5]) win = 5 + k;
          for (int n = 3; n >= 0; n--)
            if (win < 0 && intReq[n] && !srCur[0] && !srCur[1+n]) win = 5 + NUM_EXC + (3 - n);
        end
      end
      if (win >= 0) begin
        s = srCur;
        if (win == 0) begin
          s = s | 16'h00FF; s[10:8] = 3'd6;
          mSr <= srCur; mPc <= pcCur;
        end else if (win <= 4) begin
          s = s | 16'h003F; s[10:8] = 3'd7;
        end else if (win < 5 + NUM_EXC) begin
          s = s | 16'h003F; s[10:8] = 3'd6;
        end else begin
          lvl = 3 - (win - 5 - NUM_EXC);
          s = s | 16'(((1 << (lvl + 1)) - 1) << 1);
          s[10:8] = 3'(2 + lvl);
        end
        expAcc <= 1'b1; expSr <= s; expPc <= slotAddr(win); expBank <= bankFor(s);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (acceptOut !== expAcc || returnOut !== expRet || srNew !== expSr ||
          pcNew !== expPc || bankSel !== expBank) begin
        fails++;
        $display("FAIL %s model: act acc=%b ret=%b sr=%h pc=%h bank=%0d exp acc=%b ret=%b sr=%h pc=%h bank=%0d",
                 phase, acceptOut, returnOut, srNew, pcNew, bankSel,
                 expAcc, expRet, expSr, expPc, expBank);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (feedback && (acceptOut || returnOut)) begin
      srCur = srNew;
      pcCur = pcNew;
    end
  endtask

  task automatic idle();
    dbgReq = 0; critReq = '0; excReq = '0; intReq = '0; dbgRet = 0;
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 accept in reset", 64'(acceptOut), 64'd0);
    chk("R1 pc in reset", 64'(pcNew), 64'd0);
    rstN = 1'b1;
    tick();
    chk("R1 sr after reset", 64'(srNew), 64'd0);
    chk("R1 bank after reset", 64'(bankSel), 64'd0);

    // R3 / R11: masked interrupts stay out, then get in when unmasked
    phase = "R3 masking";
    srCur = 16'h0001; intReq = 4'hF;
    tick();
    chk("R3 global mask blocks interrupts", 64'(acceptOut), 64'd0);
    chk("R11 masked request leaves sr", 64'(srNew), 64'd0);
    phase = "R11 unmask";
    srCur = 16'h0010;            // only level-3 mask set
    tick();
    chk("R11 accepted once unmasked", 64'(acceptOut), 64'd1);
    chk("R5 pc of level-2 slot", 64'(pcNew), 64'(slotAddr(10)));
    chk("R7 masks levels 0..2 set", 64'(srNew), 64'h041E);
    chk("R6 bank of level 2", 64'(bankSel), 64'd3);
    tick();
    chk("R10 no strobe right after a strobe", 64'(acceptOut), 64'd0);
    idle();

    // R2: exceptions beat interrupts, lowest exception index first
    phase = "R2 priority";
    srCur = 16'h0000; excReq = 4'b0110; intReq = 4'hF;
    tick();
    chk("R2 exception 1 wins", 64'(pcNew), 64'(slotAddr(6)));
    chk("R6 exception mode", 64'(srNew), 64'h063F);
    idle();

    // R4: critical ignores every mask
    phase = "R4 critical";
    srCur = 16'h007F; critReq = 4'b1000; dbgReq = 1; excReq = '1; intReq = '1;
    tick();
    chk("R4 critical accepted under masks", 64'(acceptOut), 64'd1);
    chk("R4 critical 3 slot", 64'(pcNew), 64'(slotAddr(4)));
    chk("R6 critical mode", 64'(srNew), 64'h077F);
    chk("R6 critical bank", 64'(bankSel), 64'd5);
    idle();

    // R8: debug entry
    phase = "R8 debug entry";
    srCur = 16'hA000; pcCur = 32'h0000_2468; dbgReq = 1; critReq = 4'hF;
    tick();
    chk("R8 debug handler", 64'(pcNew), 64'(slotAddr(0)));
    chk("R8 debug flag and masks", 64'(srNew), 64'hA6FF);
    idle();

    // R9: return ignored without the debug flag
    phase = "R9 return ignored";
    srCur = 16'h0000; dbgRet = 1;
    tick();
    chk("R9 return without flag", 64'({returnOut, acceptOut}), 64'd0);
    chk("R9 outputs untouched", 64'(pcNew), 64'(slotAddr(0)));
    idle();

    // R9: return with the flag restores the saved pair and beats events
    phase = "R9 return";
    srCur = 16'hA6FF; pcCur = 32'h0000_9999; dbgRet = 1; critReq = 4'h1;
    tick();
    chk("R9 return strobe", 64'({returnOut, acceptOut}), 64'b10);
    chk("R9 restored pc", 64'(pcNew), 64'h2468);
    chk("R9 restored sr", 64'(srNew), 64'hA000);
    chk("R6 restored bank", 64'(bankSel), 64'd0);
    idle();

    // mixed random traffic with the bench acting as the core
    phase = "R2 R3 R4 R7 R10 random";
    feedback = 1'b1;
    srCur = 16'h0000;
    for (int c = 0; c < 4000; c++) begin
      dbgReq  = ($urandom_range(0, 19) == 0);
      critReq = ($urandom_range(0, 29) == 0) ? 4'($urandom) : 4'h0;
      excReq  = ($urandom_range(0, 3) == 0) ? NUM_EXC'($urandom) : '0;
      intReq  = 4'($urandom);
      dbgRet  = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 15) == 0) srCur[7:0] = 8'($urandom) & 8'h7F;
      if (!(acceptOut || returnOut)) pcCur = pcCur + 32'd2;
      tick();
    end
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule